// File: doc/BRIEF.md
# Framebuffer Controller Register Bank

This block holds the programmable state of an 8-bit-indexed framebuffer controller and exposes it on a 32-bit memory-mapped bus. The bus address is 21 bits. A single request strobe carries byte, halfword or word accesses. A read returns its data one cycle after the request. A write is applied at the end of the request cycle. When a write is narrower than a word, the block merges it into the readable value of the aligned word and writes that word back.

The display pipeline sees the stored state on dedicated outputs: screen width and height in pixels, the raw control word, the pixel depth decoded from that word, the frame base offset and the pointer position. The pipeline also has its own read ports into the three lookup stores: the 256-entry colour table, the three-entry pointer colour table and the 512-row pointer bitmap.

An interrupt line is raised by a frame-done pulse from the pipeline and is cleared by any bus write. A write to the clear trigger returns every register and every store to zero.

A two-state bus machine creates the read response. In ST_IDLE no response is presented. A read request moves it to ST_RESP (transition IDLE_TO_RESP). Another read request while in ST_RESP keeps it there (RESP_TO_RESP). Anything else while in ST_RESP returns it to ST_IDLE (RESP_TO_IDLE). Anything other than a read while in ST_IDLE keeps it in ST_IDLE (IDLE_HOLD).

Top module: `fb_regbank`

## Requirements
- R1: A read request (bus_req=1, bus_we=0) makes bus_rvalid 1 in the next cycle, with bus_rdata holding the value. In any other cycle bus_rvalid is 0. Reads change no state.
- R2: The word at offset 0x000000 reads as 0x00000010. Writes to it have no effect.
- R3: A write of v at offset 0x080118 sets scr_width to 4·v, modulo 2^16. Reading that offset returns scr_width/4.
- R4: A write of v at offset 0x080150 sets scr_height to floor(v/2). Reading that offset returns 2·scr_height.
- R5: Offset 0x080300 holds the readable control word (ctrl_word). The depth code in control bits 22:20 maps to pix_depth as follows: codes 0 to 5 give 1, 2, 4, 8, 15 and 16. Codes 6 and 7 give 0.
- R6: Offset 0x080400 drives top_base and offset 0x080638 drives cursor_pos. Both read as 0, so a sub-word write to either merges against zero.
- R7: The colour table window spans offsets 0x080800 to 0x080FFF, and the entry index is offset bits 10:3. Each entry is 24 bits, taken from the low 24 bits of the merged word, and is visible on clut_rgb for clut_idx. Reads of the window return 0.
- R8: The pointer colour window spans offsets 0x080508 to 0x08051F and holds 3 entries, indexed by (offset−0x080508)>>3. Each entry is 24 bits and readable. The entry appears on cpal_rgb for cpal_sel, and a cpal_sel of 3 gives 0.
- R9: The pointer bitmap window spans offsets 0x081000 to 0x081FFF, and the row index is offset bits 11:3. Each row is 16 bits, taken from the low half of the merged word. Rows read back zero-extended and appear on cpat_bits for cpat_idx.
- R10: bus_size 00 is a byte, 01 a halfword, and 10 or 11 a word. A byte write replaces byte lane addr[1:0], and a halfword write replaces half lane addr[1]. Lanes are little-endian, so lane 0 is bits 7:0. The new lane is taken from the low bits of bus_wdata. The other lanes keep the readable value of the aligned word.
- R11: Byte and halfword reads return the selected lane of the aligned word, zero-extended.
- R12: Any write to the word at 0x180000 clears the control, frame base, pointer position, width and height registers, and every entry of all three stores.
- R13: Writes to the timing offsets (0x080000, 0x080108 to 0x080170, 0x080200) and to undecoded offsets change nothing. All of these offsets read as 0.
- R14: The irq output is 0 after reset. A cycle with a bus write sets it to 0. Otherwise a frame_done pulse sets it to 1, so a write takes priority over frame_done in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_size | input | 2 | Access size: 00 byte, 01 halfword, 10/11 word |
| bus_addr | input | 21 | Byte offset of the access |
| bus_wdata | input | 32 | Write data; sub-word data in the low bits |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read request |
| frame_done | input | 1 | End-of-frame pulse from the display pipeline |
| irq | output | 1 | Frame interrupt |
| scr_width | output | 16 | Screen width in pixels |
| scr_height | output | 16 | Screen height in lines |
| ctrl_word | output | 32 | Control word |
| pix_depth | output | 5 | Bits per pixel decoded from the control word, 0 if unsupported |
| top_base | output | 32 | Frame base offset in video memory |
| cursor_pos | output | 32 | Pointer position word |
| clut_idx | input | 8 | Colour table read index |
| clut_rgb | output | 24 | Colour table entry at clut_idx |
| cpal_sel | input | 2 | Pointer colour index |
| cpal_rgb | output | 24 | Pointer colour entry at cpal_sel |
| cpat_idx | input | 9 | Pointer bitmap row index |
| cpat_bits | output | 16 | Pointer bitmap row at cpat_idx |

## Verification
The assertions check these properties on every cycle:
- the one-cycle read response, and no response without a read;
- that reads leave the state unchanged;
- the identifier readback;
- that writes to the timing offsets are discarded;
- the clear trigger;
- the write-over-frame priority of the interrupt;
- that the unsupported depth codes give zero.

Only the bench's scenarios can show the rest:
- the scaling arithmetic of width and height;
- the lane placement of byte and halfword merges, including merges against write-only words that read as zero;
- the decode of index bits inside the three windows, including the aliasing of offset bit 2;
- the contents seen on the display read ports after each kind of write.

// File: rtl/fb_regbank_pkg.sv
package fb_regbank_pkg;

    localparam int ADDR_W = 21;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        SZ_BYTE     = 2'b00,
        SZ_HALF     = 2'b01,
        SZ_WORD     = 2'b10,
        SZ_WORD_ALT = 2'b11
    } acc_size_e;

    typedef enum logic [3:0] {
        TGT_NONE,
        TGT_ID,
        TGT_WIDTH,
        TGT_HEIGHT,
        TGT_CTRL,
        TGT_TOP,
        TGT_CPOS,
        TGT_CPAL,
        TGT_CLUT,
        TGT_CPAT,
        TGT_WIPE,
        TGT_TIMING
    } target_e;

    typedef enum logic {
        ST_IDLE,
        ST_RESP
    } bus_state_e;

    localparam logic [ADDR_W-1:0] OFF_ID       = 21'h000000;
    localparam logic [ADDR_W-1:0] OFF_WIDTH    = 21'h080118;
    localparam logic [ADDR_W-1:0] OFF_HEIGHT   = 21'h080150;
    localparam logic [ADDR_W-1:0] OFF_CTRL     = 21'h080300;
    localparam logic [ADDR_W-1:0] OFF_TOP      = 21'h080400;
    localparam logic [ADDR_W-1:0] OFF_CPOS     = 21'h080638;
    localparam logic [ADDR_W-1:0] OFF_CPAL     = 21'h080508;
    localparam logic [ADDR_W-1:0] OFF_CPAL_END = 21'h080520;
    localparam logic [ADDR_W-1:0] OFF_CLUT     = 21'h080800;
    localparam logic [ADDR_W-1:0] OFF_CPAT     = 21'h081000;
    localparam logic [ADDR_W-1:0] OFF_WIPE     = 21'h180000;

    localparam logic [DATA_W-1:0] ID_VALUE = 32'h0000_0010;

endpackage

// File: rtl/fb_lane_unit.sv
module fb_lane_unit
    import fb_regbank_pkg::*;
(
    input  logic [1:0]        size,
    input  logic [1:0]        lane,
    input  logic [DATA_W-1:0] word_old,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] word_merged,
    output logic [DATA_W-1:0] rd_lane
);

    logic [4:0] byte_base;
    logic [4:0] half_base;

    assign byte_base = {lane, 3'b000};
    assign half_base = {lane[1], 4'b0000};

    always_comb begin
        word_merged = wdata;
        rd_lane     = word_old;
        unique case (acc_size_e'(size))
            SZ_BYTE: begin
                word_merged                  = word_old;
                word_merged[byte_base +: 8]  = wdata[7:0];
                rd_lane                      = {24'h0, word_old[byte_base +: 8]};
            end
            SZ_HALF: begin
                word_merged                  = word_old;
                word_merged[half_base +: 16] = wdata[15:0];
                rd_lane                      = {16'h0, word_old[half_base +: 16]};
            end
            default: begin
                word_merged = wdata;
                rd_lane     = word_old;
            end
        endcase
    end

endmodule

// File: rtl/fb_entry_store.sv
module fb_entry_store #(
    parameter int DEPTH  = 256,
    parameter int WIDTH  = 24,
    parameter int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [IDX_W-1:0] bus_idx,
    output logic [WIDTH-1:0] bus_data,
    input  logic [IDX_W-1:0] disp_idx,
    output logic [WIDTH-1:0] disp_data
);

    localparam bit FULL = (DEPTH == (1 << IDX_W));

    logic [WIDTH-1:0] mem [DEPTH];
    logic             wr_ok;
    logic             bus_ok;
    logic             disp_ok;

    generate
        if (FULL) begin : g_full
            assign wr_ok   = 1'b1;
            assign bus_ok  = 1'b1;
            assign disp_ok = 1'b1;
        end else begin : g_partial
            assign wr_ok   = (wr_idx   < IDX_W'(DEPTH));
            assign bus_ok  = (bus_idx  < IDX_W'(DEPTH));
            assign disp_ok = (disp_idx < IDX_W'(DEPTH));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wipe) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en && wr_ok) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign bus_data  = bus_ok  ? mem[bus_idx]  : '0;
    assign disp_data = disp_ok ? mem[disp_idx] : '0;

endmodule

// File: rtl/fb_depth_lut.sv
module fb_depth_lut (
    input  logic [2:0] code,
    output logic [4:0] depth
);

    always_comb begin
        unique case (code)
            3'd0:    depth = 5'd1;
            3'd1:    depth = 5'd2;
            3'd2:    depth = 5'd4;
            3'd3:    depth = 5'd8;
            3'd4:    depth = 5'd15;
            3'd5:    depth = 5'd16;
            default: depth = 5'd0;
        endcase
    end

endmodule

// File: rtl/fb_regbank.sv
module fb_regbank
    import fb_regbank_pkg::*;
#(
    parameter int DIM_W  = 16,
    parameter int CLUT_N = 256,
    parameter int CPAL_N = 3,
    parameter int CPAT_N = 512,
    parameter int CPAT_W = 16,
    parameter int RGB_W  = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [20:0]       bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic              frame_done,
    output logic              irq,
    output logic [15:0]       scr_width,
    output logic [15:0]       scr_height,
    output logic [31:0]       ctrl_word,
    output logic [4:0]        pix_depth,
    output logic [31:0]       top_base,
    output logic [31:0]       cursor_pos,
    input  logic [7:0]        clut_idx,
    output logic [23:0]       clut_rgb,
    input  logic [1:0]        cpal_sel,
    output logic [23:0]       cpal_rgb,
    input  logic [8:0]        cpat_idx,
    output logic [15:0]       cpat_bits
);

    localparam int CLUT_IW = $clog2(CLUT_N);
    localparam int CPAL_IW = $clog2(CPAL_N);
    localparam int CPAT_IW = $clog2(CPAT_N);
    localparam int WU_W    = DIM_W - 2;
    localparam int HU_W    = DIM_W - 1;
    localparam int WIX_W   = ADDR_W - 2;

    bus_state_e        state_q, state_d;
    target_e           tgt;
    logic [WIX_W-1:0]  wix;
    logic              rd_fire, wr_fire, wipe;
    logic [WU_W-1:0]   wunits_q;
    logic [HU_W-1:0]   hunits_q;
    logic [31:0]       ctrl_q, top_q, cpos_q;
    logic [31:0]       old_word, merged, rd_lane, rdata_q;
    logic              irq_q;
    logic [CPAL_IW-1:0] cpal_bidx;
    logic [RGB_W-1:0]  cpal_bus_data, clut_bus_data;
    logic [CPAT_W-1:0] cpat_bus_data;
    logic [2:0]        depth_code;

    assign rd_fire = bus_req && !bus_we;
    assign wr_fire = bus_req && bus_we;
    assign wix     = bus_addr[ADDR_W-1:2];
    assign wipe    = wr_fire && (tgt == TGT_WIPE);
    assign cpal_bidx = CPAL_IW'((bus_addr - OFF_CPAL) >> 3);

    // Address decode on the aligned word
    always_comb begin
        tgt = TGT_NONE;
        if (wix[WIX_W-1:10] == OFF_CPAT[ADDR_W-1:12]) begin
            tgt = TGT_CPAT;
        end else if (wix[WIX_W-1:9] == OFF_CLUT[ADDR_W-1:11]) begin
            tgt = TGT_CLUT;
        end else if (wix >= OFF_CPAL[ADDR_W-1:2] && wix < OFF_CPAL_END[ADDR_W-1:2]) begin
            tgt = TGT_CPAL;
        end else begin
            unique case (wix)
                OFF_ID[ADDR_W-1:2]:     tgt = TGT_ID;
                OFF_WIDTH[ADDR_W-1:2]:  tgt = TGT_WIDTH;
                OFF_HEIGHT[ADDR_W-1:2]: tgt = TGT_HEIGHT;
                OFF_CTRL[ADDR_W-1:2]:   tgt = TGT_CTRL;
                OFF_TOP[ADDR_W-1:2]:    tgt = TGT_TOP;
                OFF_CPOS[ADDR_W-1:2]:   tgt = TGT_CPOS;
                OFF_WIPE[ADDR_W-1:2]:   tgt = TGT_WIPE;
                19'h20000, 19'h20042, 19'h20044, 19'h20048, 19'h2004A,
                19'h2004C, 19'h2004E, 19'h20050, 19'h20052, 19'h20056,
                19'h20058, 19'h2005A, 19'h2005C, 19'h20080:
                                        tgt = TGT_TIMING;
                default:                tgt = TGT_NONE;
            endcase
        end
    end

    // Readable value of the addressed word (also the merge source)
    always_comb begin
        unique case (tgt)
            TGT_ID:     old_word = ID_VALUE;
            TGT_WIDTH:  old_word = 32'(wunits_q);
            TGT_HEIGHT: old_word = 32'({hunits_q, 1'b0});
            TGT_CTRL:   old_word = ctrl_q;
            TGT_CPAL:   old_word = 32'(cpal_bus_data);
            TGT_CPAT:   old_word = 32'(cpat_bus_data);
            default:    old_word = '0;
        endcase
    end

    fb_lane_unit u_lanes (
        .size        (bus_size),
        .lane        (bus_addr[1:0]),
        .word_old    (old_word),
        .wdata       (bus_wdata),
        .word_merged (merged),
        .rd_lane     (rd_lane)
    );

    fb_entry_store #(.DEPTH(CLUT_N), .WIDTH(RGB_W)) u_clut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .wr_en     (wr_fire && tgt == TGT_CLUT),
        .wr_idx    (bus_addr[3 +: CLUT_IW]),
        .wr_data   (merged[RGB_W-1:0]),
        .bus_idx   (bus_addr[3 +: CLUT_IW]),
        .bus_data  (clut_bus_data),
        .disp_idx  (clut_idx),
        .disp_data (clut_rgb)
    );

    fb_entry_store #(.DEPTH(CPAL_N), .WIDTH(RGB_W)) u_cpal (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .wr_en     (wr_fire && tgt == TGT_CPAL),
        .wr_idx    (cpal_bidx),
        .wr_data   (merged[RGB_W-1:0]),
        .bus_idx   (cpal_bidx),
        .bus_data  (cpal_bus_data),
        .disp_idx  (cpal_sel),
        .disp_data (cpal_rgb)
    );

    fb_entry_store #(.DEPTH(CPAT_N), .WIDTH(CPAT_W)) u_cpat (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe      (wipe),
        .wr_en     (wr_fire && tgt == TGT_CPAT),
        .wr_idx    (bus_addr[3 +: CPAT_IW]),
        .wr_data   (merged[CPAT_W-1:0]),
        .bus_idx   (bus_addr[3 +: CPAT_IW]),
        .bus_data  (cpat_bus_data),
        .disp_idx  (cpat_idx),
        .disp_data (cpat_bits)
    );

    // Scalar registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wunits_q <= '0;
            hunits_q <= '0;
            ctrl_q   <= '0;
            top_q    <= '0;
            cpos_q   <= '0;
        end else if (wipe) begin
            wunits_q <= '0;
            hunits_q <= '0;
            ctrl_q   <= '0;
            top_q    <= '0;
            cpos_q   <= '0;
        end else if (wr_fire) begin
            unique case (tgt)
                TGT_WIDTH:  wunits_q <= merged[WU_W-1:0];
                TGT_HEIGHT: hunits_q <= merged[DIM_W-1:1];
                TGT_CTRL:   ctrl_q   <= merged;
                TGT_TOP:    top_q    <= merged;
                TGT_CPOS:   cpos_q   <= merged;
                default:    ;
            endcase
        end
    end

    // Interrupt: write clears with priority, frame end sets
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          irq_q <= 1'b0;
        else if (wr_fire)    irq_q <= 1'b0;
        else if (frame_done) irq_q <= 1'b1;
    end

    // Bus response machine: next state
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: state_d = rd_fire ? ST_RESP : ST_IDLE;
            ST_RESP: state_d = rd_fire ? ST_RESP : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Bus response machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Bus response machine: outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       rdata_q <= '0;
        else if (rd_fire) rdata_q <= rd_lane;
    end

    assign depth_code = ctrl_q[22:20];

    fb_depth_lut u_depth (
        .code  (depth_code),
        .depth (pix_depth)
    );

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = (state_q == ST_RESP);
    assign irq        = irq_q;
    assign scr_width  = {wunits_q, 2'b00};
    assign scr_height = {1'b0, hunits_q};
    assign ctrl_word  = ctrl_q;
    assign top_base   = top_q;
    assign cursor_pos = cpos_q;

    AST_READ_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> bus_rvalid); // R1
    AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> !bus_rvalid); // R1
    AST_READ_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire |=> ($stable(ctrl_word) && $stable(scr_width) && $stable(scr_height)
                     && $stable(top_base) && $stable(cursor_pos))); // R1
    AST_ID_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && bus_addr == 21'h0 && bus_size[1]) |=> bus_rdata == 32'h10); // R2
    AST_DEPTH_UNSUPPORTED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[22:21] == 2'b11) |-> pix_depth == 5'd0); // R5
    AST_WIPE_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && wix == OFF_WIPE[ADDR_W-1:2]) |=>
        (ctrl_word == 32'h0 && top_base == 32'h0 && cursor_pos == 32'h0
         && scr_width == 16'h0 && scr_height == 16'h0)); // R12
    AST_TIMING_DISCARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && tgt == TGT_TIMING) |=>
        ($stable(ctrl_word) && $stable(scr_width) && $stable(scr_height)
         && $stable(top_base) && $stable(cursor_pos))); // R13
    AST_WRITE_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        wr_fire |=> !irq); // R14
    AST_FRAME_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !wr_fire) |=> irq); // R14

endmodule

// File: tb/test_fb_regbank.sv
`timescale 1ns/1ps
module test_fb_regbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0, frame_done = 1'b0;
    logic [1:0]  bus_size = 2'b10;
    logic [20:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, ctrl_word, top_base, cursor_pos;
    logic        bus_rvalid, irq;
    logic [15:0] scr_width, scr_height, cpat_bits;
    logic [4:0]  pix_depth;
    logic [7:0]  clut_idx = '0;
    logic [1:0]  cpal_sel = '0;
    logic [8:0]  cpat_idx = '0;
    logic [23:0] clut_rgb, cpal_rgb;

    always #10 clk = ~clk;

    fb_regbank i_fb_regbank (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .frame_done(frame_done),
        .irq(irq), .scr_width(scr_width), .scr_height(scr_height),
        .ctrl_word(ctrl_word), .pix_depth(pix_depth), .top_base(top_base),
        .cursor_pos(cursor_pos), .clut_idx(clut_idx), .clut_rgb(clut_rgb),
        .cpal_sel(cpal_sel), .cpal_rgb(cpal_rgb), .cpat_idx(cpat_idx),
        .cpat_bits(cpat_bits)
    );

    int n_checks = 0;
    int n_errors = 0;
    bit cmp_on = 1'b0;

    // Behavioural reference model, pixel units
    int unsigned m_width, m_height, m_ctrl, m_top, m_cpos, m_rdata;
    int unsigned m_clut [256];
    int unsigned m_cpal [3];
    int unsigned m_cpat [512];
    bit m_irq, m_rvalid;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic void mdl_clear();
        m_width = 0; m_height = 0; m_ctrl = 0; m_top = 0; m_cpos = 0;
        for (int i = 0; i < 256; i++) m_clut[i] = 0;
        for (int i = 0; i < 3; i++)   m_cpal[i] = 0;
        for (int i = 0; i < 512; i++) m_cpat[i] = 0;
    endfunction

    function automatic int unsigned mdl_word(input int unsigned a);
        if (a >= 32'h081000 && a < 32'h082000) return m_cpat[(a - 32'h081000) >> 3];
        if (a >= 32'h080800 && a < 32'h081000) return 0;
        if (a >= 32'h080508 && a < 32'h080520) return m_cpal[(a - 32'h080508) >> 3];
        case (a)
            32'h000000: return 32'h10;
            32'h080118: return m_width / 4;
            32'h080150: return m_height * 2;
            32'h080300: return m_ctrl;
            default:    return 0;
        endcase
    endfunction

    function automatic int unsigned mdl_merge(input int unsigned old, input int unsigned wd,
                                              input int sz, input int unsigned lane);
        int unsigned sh;
        if (sz == 0) begin
            sh = 8 * lane;
            return (old & ~(32'hFF << sh)) | ((wd & 32'hFF) << sh);
        end
        if (sz == 1) begin
            sh = 16 * (lane / 2);
            return (old & ~(32'hFFFF << sh)) | ((wd & 32'hFFFF) << sh);
        end
        return wd;
    endfunction

    function automatic int unsigned mdl_lane(input int unsigned v, input int sz, input int unsigned lane);
        if (sz == 0) return (v >> (8 * lane)) & 32'hFF;
        if (sz == 1) return (v >> (16 * (lane / 2))) & 32'hFFFF;
        return v;
    endfunction

    function automatic void mdl_write(input int unsigned a, input int unsigned v);
        if (a >= 32'h081000 && a < 32'h082000)      m_cpat[(a - 32'h081000) >> 3] = v & 32'hFFFF;
        else if (a >= 32'h080800 && a < 32'h081000) m_clut[(a - 32'h080800) >> 3] = v & 32'hFFFFFF;
        else if (a >= 32'h080508 && a < 32'h080520) m_cpal[(a - 32'h080508) >> 3] = v & 32'hFFFFFF;
        else case (a)
            32'h080118: m_width  = (v * 4) & 32'hFFFF;
            32'h080150: m_height = (v >> 1) & 32'h7FFF;
            32'h080300: m_ctrl   = v;
            32'h080400: m_top    = v;
            32'h080638: m_cpos   = v;
            32'h180000: mdl_clear();
            default: ;
        endcase
    endfunction

    function automatic int unsigned mdl_depth(input int unsigned c);
        case (c)
            0: return 1;  1: return 2;  2: return 4;
            3: return 8;  4: return 15; 5: return 16;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        int unsigned a, old;
        if (!rst_n) begin
            mdl_clear(); m_irq = 0; m_rvalid = 0; m_rdata = 0;
        end else begin
            m_rvalid = bus_req && !bus_we;
            if (bus_req) begin
                a   = {11'h0, bus_addr[20:2], 2'b00};
                old = mdl_word(a);
                if (!bus_we) m_rdata = mdl_lane(old, int'(bus_size), bus_addr[1:0]);
                else mdl_write(a, mdl_merge(old, bus_wdata, int'(bus_size), bus_addr[1:0]));
            end
            if (bus_req && bus_we) m_irq = 0;
            else if (frame_done)   m_irq = 1;
        end
    end

    // Every-cycle comparison, mid high phase
    always @(posedge clk) begin
        #5;
        if (cmp_on) begin
            chk("R1 rvalid", {31'h0, bus_rvalid}, {31'h0, m_rvalid});
            if (m_rvalid) chk("R11 rdata", bus_rdata, m_rdata);
            chk("R3 width", {16'h0, scr_width}, m_width);
            chk("R4 height", {16'h0, scr_height}, m_height);
            chk("R5 ctrl", ctrl_word, m_ctrl);
            chk("R5 depth", {27'h0, pix_depth}, mdl_depth((m_ctrl >> 20) & 7));
            chk("R6 top", top_base, m_top);
            chk("R6 cursor", cursor_pos, m_cpos);
            chk("R14 irq", {31'h0, irq}, {31'h0, m_irq});
        end
    end

    task automatic bus_wr(input int unsigned a, input int sz, input int unsigned d);
        @(negedge clk);
        bus_req = 1; bus_we = 1; bus_addr = a[20:0]; bus_size = sz[1:0]; bus_wdata = d;
        @(posedge clk); #6;
        bus_req = 0; bus_we = 0;
    endtask

    task automatic bus_rd(input int unsigned a, input int sz, input int unsigned exp, input string tag);
        @(negedge clk);
        bus_req = 1; bus_we = 0; bus_addr = a[20:0]; bus_size = sz[1:0];
        @(posedge clk); #6;
        chk(tag, bus_rdata, exp);
        bus_req = 0;
    endtask

    task automatic disp(input int ci, input int cs, input int pi,
                        input int unsigned e_clut, input int unsigned e_cpal, input int unsigned e_cpat,
                        input string tag);
        clut_idx = ci[7:0]; cpal_sel = cs[1:0]; cpat_idx = pi[8:0];
        #1;
        chk({tag, " clut"}, {8'h0, clut_rgb}, e_clut);
        chk({tag, " cpal"}, {8'h0, cpal_rgb}, e_cpal);
        chk({tag, " cpat"}, {16'h0, cpat_bits}, e_cpat);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    initial begin
        #4_000_000;
        n_checks++; n_errors++;
        $display("FAIL R1 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int unsigned toffs [15];
        toffs = '{32'h080000, 32'h080108, 32'h080110, 32'h080120, 32'h080128,
                  32'h080130, 32'h080138, 32'h080140, 32'h080148, 32'h080158,
                  32'h080160, 32'h080168, 32'h080170, 32'h080200, 32'h0A0000};
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        cmp_on = 1;
        // reset state (R12 style zeros, R14 irq low)
        chk("R14 irq after reset", {31'h0, irq}, 32'h0);
        chk("R1 rvalid after reset", {31'h0, bus_rvalid}, 32'h0);
        disp(0, 0, 0, 0, 0, 0, "R7 reset");

        // R2 identifier
        bus_rd(32'h000000, 2, 32'h10, "R2 id word");
        bus_rd(32'h000000, 0, 32'h10, "R11 id byte0");
        bus_rd(32'h000001, 0, 32'h00, "R11 id byte1");
        bus_wr(32'h000000, 2, 32'hDEADBEEF);
        bus_rd(32'h000000, 2, 32'h10, "R2 id after write");

        // R3 / R4 scaling
        bus_wr(32'h080118, 2, 32'h50);
        chk("R3 width px", {16'h0, scr_width}, 32'h140);
        bus_rd(32'h080118, 2, 32'h50, "R3 width read");
        bus_wr(32'h080150, 2, 32'h3FF);
        chk("R4 height px", {16'h0, scr_height}, 32'h1FF);
        bus_rd(32'h080150, 2, 32'h3FE, "R4 height read");

        // R5 depth table
        for (int c = 0; c < 8; c++) begin
            bus_wr(32'h080300, 2, (c << 20) | 32'h400);
            chk("R5 depth code", {27'h0, pix_depth}, mdl_depth(c));
        end
        bus_rd(32'h080300, 2, (7 << 20) | 32'h400, "R5 ctrl read");
        // R10 byte merge into control
        bus_wr(32'h080302, 0, 32'h50);
        chk("R10 ctrl byte2", ctrl_word, 32'h0050_0400);
        chk("R5 depth after merge", {27'h0, pix_depth}, 32'd16);
        bus_wr(32'h080302, 1, 32'hABCD);
        chk("R10 ctrl half1", ctrl_word, 32'hABCD_0400);

        // R6 frame base / pointer position
        bus_wr(32'h080400, 2, 32'h12345678);
        chk("R6 top word", top_base, 32'h12345678);
        bus_rd(32'h080400, 2, 32'h0, "R6 top read zero");
        bus_wr(32'h080401, 0, 32'hAB);
        chk("R6 top byte merge vs zero", top_base, 32'h0000AB00);
        bus_wr(32'h080638, 2, 32'h0004_0020);
        chk("R6 cursor word", cursor_pos, 32'h0004_0020);
        bus_rd(32'h080638, 2, 32'h0, "R6 cursor read zero");

        // R7 colour table
        bus_wr(32'h080828, 2, 32'hFFA1B2C3);
        disp(5, 0, 0, 32'hA1B2C3, 0, 0, "R7 entry5");
        bus_rd(32'h080828, 2, 32'h0, "R7 read zero");
        bus_wr(32'h08082C, 2, 32'h00102030);
        disp(5, 0, 0, 32'h102030, 0, 0, "R7 bit2 alias");
        bus_wr(32'h08083A, 1, 32'h00EE);
        disp(7, 0, 0, 32'hEE0000, 0, 0, "R10 clut half merge");
        bus_wr(32'h080FF8, 2, 32'h00777777);
        disp(255, 0, 0, 32'h777777, 0, 0, "R7 entry255");

        // R8 pointer colours
        bus_wr(32'h080508, 2, 32'h00445566);
        bus_wr(32'h080518, 2, 32'h00112233);
        bus_rd(32'h080518, 2, 32'h00112233, "R8 cpal2 read");
        bus_wr(32'h080509, 0, 32'h77);
        bus_rd(32'h080508, 2, 32'h00447766, "R10 cpal byte merge");
        bus_rd(32'h08051A, 1, 32'h0011, "R11 half read");
        disp(0, 2, 0, 32'hA1B2C3 & 0, 32'h112233, 0, "R8 sel2");
        disp(0, 3, 0, 0, 0, 0, "R8 sel3");

        // R9 pointer bitmap
        bus_wr(32'h081FF8, 2, 32'hFFFF1234);
        bus_rd(32'h081FF8, 2, 32'h00001234, "R9 row511 read");
        disp(0, 0, 511, 0, 32'h447766, 32'h1234, "R9 row511");
        bus_wr(32'h081001, 0, 32'hC3);
        disp(0, 0, 0, 0, 32'h447766, 32'hC300, "R9 row0 byte");

        // R13 timing and undecoded writes
        for (int i = 0; i < 15; i++) bus_wr(toffs[i], 2, 32'hFFFFFFFF);
        for (int i = 0; i < 15; i++) bus_rd(toffs[i], 2, 32'h0, "R13 read zero");
        chk("R13 ctrl kept", ctrl_word, 32'hABCD_0400);

        // R1 back-to-back reads
        bus_rd(32'h080300, 2, 32'hABCD_0400, "R1 burst a");
        bus_rd(32'h080118, 2, 32'h50, "R1 burst b");
        bus_rd(32'h080300, 0, 32'h00, "R1 burst c");

        // R14 interrupt
        @(negedge clk); frame_done = 1;
        @(posedge clk); #6; frame_done = 0;
        chk("R14 frame raises", {31'h0, irq}, 32'h1);
        bus_rd(32'h000000, 2, 32'h10, "R14 read keeps");
        chk("R14 read no clear", {31'h0, irq}, 32'h1);
        bus_wr(32'h0A0000, 2, 32'h0);
        chk("R14 write clears", {31'h0, irq}, 32'h0);
        @(negedge clk); frame_done = 1;
        bus_req = 1; bus_we = 1; bus_addr = 21'h0A0000; bus_size = 2'b10;
        @(posedge clk); #6; frame_done = 0; bus_req = 0; bus_we = 0;
        chk("R14 write wins", {31'h0, irq}, 32'h0);
        @(negedge clk); frame_done = 1;
        @(posedge clk); #6; frame_done = 0;

        // R12 clear trigger via a byte write
        bus_wr(32'h180003, 0, 32'h5A);
        chk("R12 ctrl", ctrl_word, 32'h0);
        chk("R12 width", {16'h0, scr_width}, 32'h0);
        chk("R12 top", top_base, 32'h0);
        chk("R12 irq low", {31'h0, irq}, 32'h0);
        disp(5, 2, 511, 0, 0, 0, "R12 stores");
        bus_rd(32'h080508, 2, 32'h0, "R12 cpal read");

        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule